// File: doc/BRIEF.md
# Cascadable Up/Down Counter

A binary counter of parameterised width that counts up or down. It can be loaded in parallel on a clock edge, it has a clock enable, and it has an asynchronous clear. The clear also acts as the power-on reset. The counter drives three outputs: the current count, a terminal-count flag, and an enable-out. The terminal-count flag is decoded against the direction input.

Identical stages chain into a longer counter. Each stage's enable-out drives the next stage's enable. Clock, direction, load and clear go to every stage in parallel. When the shared load is asserted, every stage captures its own slice of the wide data word on the same edge, whatever its enable is. The chain then behaves as a single counter of the combined width. Counting wraps modulo 2^WIDTH in both directions.

All pins are plain control and data signals. There is no streaming handshake, and nothing can stall the counter apart from its enable.

Top module: `cascade_updn_counter`

## Requirements
- R1: While `clr_a` is high, `count`, `term_cnt` and `en_out` are all 0 at once, without waiting for a clock edge, and clock edges have no effect. After `clr_a` falls, counting resumes from zero.
- R2: A rising clock edge with `load` high copies `load_data` into `count`, whether `cnt_en` is high or low. Load takes priority over counting.
- R3: A rising edge with `load` low, `cnt_en` high and `count_up` high adds one to `count`. All ones wraps to zero.
- R4: A rising edge with `load` low, `cnt_en` high and `count_up` low subtracts one from `count`. Zero wraps to all ones.
- R5: A rising edge with `load` and `cnt_en` both low leaves `count` unchanged, whatever `count_up` and `load_data` are.
- R6: Outside clear, `term_cnt` is 1 exactly when `count` is all ones with `count_up` = 1, or `count` is zero with `count_up` = 0. It follows a change of `count_up` within the same cycle.
- R7: `en_out` equals `term_cnt` AND `cnt_en`.
- R8: Two 8-bit stages, the low stage's `en_out` driving the high stage's `cnt_en`, count, load and wrap exactly as one 16-bit counter. The chain's terminal flag is the high stage's `en_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| clr_a | input | 1 | Asynchronous clear, active high |
| load | input | 1 | Synchronous parallel load |
| cnt_en | input | 1 | Count enable (chain input) |
| count_up | input | 1 | Direction: 1 up, 0 down |
| load_data | input | WIDTH | Parallel load value |
| count | output | WIDTH | Current count |
| term_cnt | output | 1 | Terminal count for the current direction |
| en_out | output | 1 | Enable for the next stage |

## Verification
`count` settles one rising edge after the load or enable that caused it. `term_cnt` and `en_out` are combinational from `count`, `count_up` and `cnt_en`, so they are valid within the same cycle. The clear acts at once, independent of the clock.

The driver sets inputs at the falling edge and queues the value expected after the next rising edge. The monitor pops that value one time unit after the rising edge, while the inputs are still stable, and compares count and flags.

The clear is checked one time unit after it rises in mid-cycle, and again after the rising edge it must ignore.

// File: rtl/cuc_pkg.sv
package cuc_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cuc_op_decode.sv
// Resolves load over enable, enable over hold.
module cuc_op_decode
  import cuc_pkg::*;
(
  input  logic    load,
  input  logic    cnt_en,
  input  logic    count_up,
  output cnt_op_e op
);
  always_comb begin
    if (load)        op = OP_LOAD;
    else if (!cnt_en) op = OP_HOLD;
    else if (count_up) op = OP_INC;
    else              op = OP_DEC;
  end
endmodule

// File: rtl/cuc_next_count.sv
// Next-state value for the count register; wraps modulo 2^WIDTH.
module cuc_next_count
  import cuc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  cnt_op_e          op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] load_data,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    unique case (op)
      OP_LOAD: nxt = load_data;
      OP_INC:  nxt = cur + ONE;
      OP_DEC:  nxt = cur - ONE;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/cuc_term_detect.sv
// Direction-dependent terminal count and chain enable, held low during clear.
module cuc_term_detect #(
  parameter int WIDTH = 8
) (
  input  logic             clr_a,
  input  logic             cnt_en,
  input  logic             count_up,
  input  logic [WIDTH-1:0] cur,
  output logic             term_cnt,
  output logic             en_out
);
  logic [WIDTH-1:0] ones_run;
  logic [WIDTH-1:0] zeros_run;

  // Ripple AND chains, one cell per bit.
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      if (b == 0) begin : g_first
        assign ones_run[b]  = cur[b];
        assign zeros_run[b] = ~cur[b];
      end else begin : g_rest
        assign ones_run[b]  = ones_run[b-1] & cur[b];
        assign zeros_run[b] = zeros_run[b-1] & ~cur[b];
      end
    end
  endgenerate

  logic hit;
  assign hit      = count_up ? ones_run[WIDTH-1] : zeros_run[WIDTH-1];
  assign term_cnt = hit & ~clr_a;
  assign en_out   = term_cnt & cnt_en;
endmodule

// File: rtl/cascade_updn_counter.sv
module cascade_updn_counter
  import cuc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_a,
  input  logic             load,
  input  logic             cnt_en,
  input  logic             count_up,
  input  logic [WIDTH-1:0] load_data,
  output logic [WIDTH-1:0] count,
  output logic             term_cnt,
  output logic             en_out
);
  cnt_op_e          op;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  cuc_op_decode u_dec (
    .load     (load),
    .cnt_en   (cnt_en),
    .count_up (count_up),
    .op       (op)
  );

  cuc_next_count #(.WIDTH(WIDTH)) u_nxt (
    .op        (op),
    .cur       (cnt_q),
    .load_data (load_data),
    .nxt       (cnt_d)
  );

  always_ff @(posedge clk or posedge clr_a) begin
    if (clr_a) cnt_q <= '0;
    else       cnt_q <= cnt_d;
  end

  cuc_term_detect #(.WIDTH(WIDTH)) u_tc (
    .clr_a    (clr_a),
    .cnt_en   (cnt_en),
    .count_up (count_up),
    .cur      (cnt_q),
    .term_cnt (term_cnt),
    .en_out   (en_out)
  );

  assign count = cnt_q;
endmodule

// File: rtl/cuc_checker.sv
module cuc_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             clr_a,
  input logic             load,
  input logic             cnt_en,
  input logic             count_up,
  input logic [WIDTH-1:0] load_data,
  input logic [WIDTH-1:0] count,
  input logic             term_cnt,
  input logic             en_out
);
  always @(negedge clk) begin
    if (clr_a === 1'b1) begin
      assert_clear_forces_low_R1: assert (count == '0 && !term_cnt && !en_out);
    end
  end

  assert_load_captures_R2: assert property (@(posedge clk) disable iff (clr_a)
    load |=> count == $past(load_data));

  assert_increment_R3: assert property (@(posedge clk) disable iff (clr_a)
    (!load && cnt_en && count_up) |=> count == $past(count) + WIDTH'(1));

  assert_decrement_R4: assert property (@(posedge clk) disable iff (clr_a)
    (!load && cnt_en && !count_up) |=> count == $past(count) - WIDTH'(1));

  assert_hold_R5: assert property (@(posedge clk) disable iff (clr_a)
    (!load && !cnt_en) |=> $stable(count));

  assert_tc_up_R6: assert property (@(posedge clk) disable iff (clr_a)
    (count_up && count == '1) |-> term_cnt);

  assert_tc_down_R6: assert property (@(posedge clk) disable iff (clr_a)
    (!count_up && count == '0) |-> term_cnt);

  assert_tc_only_at_end_R6: assert property (@(posedge clk) disable iff (clr_a)
    term_cnt |-> (count == (count_up ? '1 : '0)));

  assert_enout_gated_R7: assert property (@(posedge clk) disable iff (clr_a)
    en_out |-> (cnt_en && term_cnt));

  assert_enout_passes_R7: assert property (@(posedge clk) disable iff (clr_a)
    (cnt_en && term_cnt) |-> en_out);
endmodule

bind cascade_updn_counter cuc_checker #(.WIDTH(WIDTH)) u_cuc_chk (
  .clk       (clk),
  .clr_a     (clr_a),
  .load      (load),
  .cnt_en    (cnt_en),
  .count_up  (count_up),
  .load_data (load_data),
  .count     (count),
  .term_cnt  (term_cnt),
  .en_out    (en_out)
);

// File: tb/cascade_updn_counter_tb_top.sv
module cascade_updn_counter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        clr, load, ce, up;
  logic [15:0] din;
  logic [7:0]  q_lo, q_hi;
  logic        tc_lo, tc_hi, ceo_lo, ceo_hi;

  cascade_updn_counter #(.WIDTH(8)) dut_i (
    .clk(clk), .clr_a(clr), .load(load), .cnt_en(ce), .count_up(up),
    .load_data(din[7:0]), .count(q_lo), .term_cnt(tc_lo), .en_out(ceo_lo)
  );

  cascade_updn_counter #(.WIDTH(8)) dut_hi_i (
    .clk(clk), .clr_a(clr), .load(load), .cnt_en(ceo_lo), .count_up(up),
    .load_data(din[15:8]), .count(q_hi), .term_cnt(tc_hi), .en_out(ceo_hi)
  );

  int checks = 0;
  int errors = 0;
  logic [15:0] model;
  logic [17:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: inputs at falling edge; expected post-edge state into the queue.
  task automatic drive(input logic l, input logic e, input logic u,
                       input logic [15:0] dv, input string tag);
    @(negedge clk);
    load = l; ce = e; up = u; din = dv;
    if (l)      model = dv;
    else if (e) model = u ? model + 16'd1 : model - 16'd1;
    exp_q.push_back({e, u, model});
    tag_q.push_back(tag);
  endtask

  // Monitor: one unit after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [17:0] it;
        string t;
        logic e, u, xtlo, xthi, xtall;
        logic [15:0] m;
        it = exp_q.pop_front();
        t  = tag_q.pop_front();
        e = it[17]; u = it[16]; m = it[15:0];
        xtlo  = u ? &m[7:0]  : ~|m[7:0];
        xthi  = u ? &m[15:8] : ~|m[15:8];
        xtall = u ? &m : ~|m;
        chk({q_hi, q_lo} == m, t, "count16", {q_hi, q_lo}, m);
        chk(tc_lo == xtlo, {t, " R6"}, "tc_lo", 16'(tc_lo), 16'(xtlo));
        chk(tc_hi == xthi, {t, " R6"}, "tc_hi", 16'(tc_hi), 16'(xthi));
        chk(ceo_lo == (xtlo & e), {t, " R7"}, "ceo_lo", 16'(ceo_lo), 16'(xtlo & e));
        chk(ceo_hi == (xtall & e), {t, " R8"}, "chain_ceo", 16'(ceo_hi), 16'(xtall & e));
      end
    end
  end

  task automatic clear_mid_cycle();
    @(negedge clk);
    load = 1'b0; ce = 1'b1; up = 1'b0;
    #(CLK_PERIOD/4);
    clr = 1'b1;
    #1;
    chk({q_hi, q_lo} == 16'h0, "R1 mid-cycle", "count", {q_hi, q_lo}, 16'h0);
    chk(!tc_lo && !tc_hi, "R1 mid-cycle", "tc", {14'h0, tc_hi, tc_lo}, 16'h0);
    chk(!ceo_lo && !ceo_hi, "R1 mid-cycle", "ceo", {14'h0, ceo_hi, ceo_lo}, 16'h0);
    @(posedge clk);
    #1;
    chk({q_hi, q_lo} == 16'h0, "R1 edge ignored", "count", {q_hi, q_lo}, 16'h0);
    @(negedge clk);
    ce = 1'b0;
    clr = 1'b0;
    model = 16'h0;
    #1;
    chk(tc_lo == 1'b1, "R6 zero going down", "tc_lo", 16'(tc_lo), 16'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clr = 1'b1; load = 1'b0; ce = 1'b0; up = 1'b0; din = 16'h0; model = 16'h0;
    repeat (2) @(posedge clk);
    #1;
    chk({q_hi, q_lo} == 16'h0, "R1 power-up", "count", {q_hi, q_lo}, 16'h0);
    chk(!tc_lo && !ceo_lo, "R1 power-up", "tc/ceo", {14'h0, tc_lo, ceo_lo}, 16'h0);
    @(negedge clk);
    clr = 1'b0;
    #1;
    chk(tc_lo == 1'b1, "R6 after release", "tc_lo", 16'(tc_lo), 16'h1);
    chk(ceo_lo == 1'b0, "R7 enable low", "ceo_lo", 16'(ceo_lo), 16'h0);

    drive(1'b1, 1'b0, 1'b1, 16'h12FE, "R2 load enable low");
    repeat (3) drive(1'b0, 1'b1, 1'b1, 16'h0, "R3 R8 carry up");
    drive(1'b0, 1'b0, 1'b0, 16'hAAAA, "R5 hold down");
    drive(1'b0, 1'b0, 1'b1, 16'h5555, "R5 hold up");
    drive(1'b1, 1'b1, 1'b1, 16'hFFFD, "R2 load over enable");
    repeat (5) drive(1'b0, 1'b1, 1'b1, 16'h0, "R3 R8 wrap up");
    drive(1'b1, 1'b0, 1'b0, 16'h0002, "R2 load");
    repeat (4) drive(1'b0, 1'b1, 1'b0, 16'h0, "R4 R8 wrap down");
    drive(1'b1, 1'b0, 1'b0, 16'h0100, "R2 load");
    drive(1'b0, 1'b1, 1'b0, 16'h0, "R4 R8 borrow");
    drive(1'b0, 1'b0, 1'b1, 16'h0, "R5 hold tc up");
    drive(1'b0, 1'b0, 1'b0, 16'h0, "R5 hold tc down");
    @(posedge clk);
    #2;
    clear_mid_cycle();
    repeat (2) drive(1'b0, 1'b1, 1'b1, 16'h0, "R1 R3 resume");
    drive(1'b0, 1'b0, 1'b1, 16'h0, "R5 final hold");
    repeat (3) @(posedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule